// File: doc/BRIEF.md
# Big-Integer by Signed Scalar Multiply-Accumulate Engine

This engine multiplies an unsigned big integer by a signed 64-bit scalar and adds a signed 64-bit carry to the product. The big integer is held as up to eight 64-bit limbs in a small internal buffer, with the least significant limb at index 0. A start pulse latches the vector length and the operands and copies the carry-in into a carry register. The engine then processes one limb per clock cycle, from index 0 upward. In each step it multiplies the limb, read as unsigned, by the scalar, read as two's complement. It adds the carry register, sign-extended, to that product, which gives a 128-bit result. The low half of the result replaces the limb in place. The high half goes back into the carry register and becomes the addend of the next step.

Software loads the limbs through a write port and starts the engine. It waits for the one-cycle done pulse, then reads the product limbs back through the read port. The carry register is exposed as the carry-out and holds the top 64 bits of the result. Taken together, the limbs and the carry-out form the signed value limbs × scalar + carry-in, modulo 2^(64·(VL+1)).

Top module: `bigint_scalar_mac`

## Requirements
- R1: Each step computes limb × scalar + carry over 128 bits, with the limb unsigned and the scalar and carry two's complement. Bits 63:0 of the result overwrite that same limb, and bits 127:64 become the new carry.
- R2: Limbs are processed in ascending index order, from 0 to VL−1. For VL=3 with limbs {0x1357_0000_9BDF_0000, 0x9ABC_0000_DEF0_0000, 0x1234_0000_5678_0000}, scalar −0x1_0001 and carry-in −0xFEDC, the limbs become {0xECA8_6420_6420_0124, 0x6543_210F_210F_ECA8, 0xEDCB_A987_A987_6543}.
- R3: The carry register is loaded from carry_in when a start is accepted. After the last step it holds the final high half, and carry_out shows that value (0xFFFF_FFFF_FFFF_EDCB for the R2 example).
- R4: Limbs at indices VL and above are not modified by an operation.
- R5: VL ranges from 1 to 8. A vlen value above 8 is treated as 8.
- R6: A start with vlen=0 changes no limb, raises done on the next cycle and leaves carry_out equal to carry_in.
- R7: done is high for exactly one cycle. It first appears VL+1 rising edges after the edge that accepts the start, and the engine is idle again on the following cycle.
- R8: A start pulse that arrives while the engine is busy, including the done cycle, is ignored.
- R9: buf_rdata shows, combinationally, the limb at buf_addr. A buf_we write is performed only while the engine is idle and is ignored while busy.
- R10: After a synchronous active-low reset, busy and done are 0, carry_out is 0 and every limb reads 0.
- R11: carry_out holds its value while the engine is idle and no start is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| vlen | input | 4 | Number of limbs to process (0..8, larger values clamp to 8) |
| scalar | input | 64 | Signed multiplier |
| carry_in | input | 64 | Signed initial carry |
| buf_we | input | 1 | Limb buffer write enable (idle only) |
| buf_addr | input | 3 | Limb index for read and write |
| buf_wdata | input | 64 | Limb write data |
| buf_rdata | output | 64 | Limb at buf_addr |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 64 | Carry register, final high half after an operation |

## Verification
The bench goes after the signed corners. These are a most-negative scalar, all-ones limbs and large negative carries. A design that sign-extended the limb, or that added the carry zero-extended, would produce wrong high halves that then spread into every later limb. The bench uses the stated three-limb example to catch a reversed processing order or a carry that is not chained between steps. It checks the untouched upper limbs, a zero length and a clamped length to catch off-by-one loop bounds. It also injects a start and a write in the middle of an operation to expose a design that restarts or lets the host corrupt its working buffer.

// File: rtl/bsm_pkg.sv
// Shared types for the big-integer scalar multiply-accumulate engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bsm_state_e;
endpackage

// File: rtl/bsm_step.sv
// Single unsigned-by-signed multiply-add step, purely combinational.
// Returns limb*scalar + addend split into low and high halves.
// Assumes: limb is unsigned, scalar and addend are two's complement.
module bsm_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] limb,
    input  logic [W-1:0] scalar,
    input  logic [W-1:0] addend,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic [2*W-1:0] limb_x;
    logic [2*W-1:0] scal_x;
    logic [2*W-1:0] add_x;
    logic [2*W-1:0] full;

    // Widen operands: zero-extend the limb, sign-extend the others.
    always_comb begin
        limb_x = {{W{1'b0}}, limb};
        scal_x = {{W{scalar[W-1]}}, scalar};
        add_x  = {{W{addend[W-1]}}, addend};
        full   = limb_x * scal_x + add_x;
        lo     = full[W-1:0];
        hi     = full[2*W-1:W];
    end
endmodule

// File: rtl/bsm_limb_buf.sv
// Limb storage: one write port, two combinational read ports.
// Assumes: the caller resolves write priority before this module.
module bsm_limb_buf #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [W-1:0]     rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [W-1:0]     rdata_b
);
    logic [W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each entry: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && (waddr == IDX_W'(g)))
                ent[g] <= wdata;
        end
    end

    // Read ports are plain array lookups.
    always_comb begin
        rdata_a = ent[raddr_a];
        rdata_b = ent[raddr_b];
    end
endmodule

// File: rtl/bsm_ctrl.sv
// Sequencer: IDLE -> RUN (one limb per cycle) -> DONE -> IDLE.
// Assumes: start is only honoured in IDLE; vlen above MAX_LIMBS clamps.
module bsm_ctrl
    import bsm_pkg::*;
#(
    parameter int MAX_LIMBS = 8,
    parameter int LEN_W     = 4,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vlen,
    output logic             busy,
    output logic             done,
    output logic             step_en,
    output logic             load_carry,
    output logic [IDX_W-1:0] idx
);
    bsm_state_e       state;
    logic [IDX_W-1:0] last_idx;
    logic [LEN_W-1:0] eff_len;

    // Clamp the requested length to the buffer depth.
    always_comb begin
        eff_len = (vlen > LEN_W'(MAX_LIMBS)) ? LEN_W'(MAX_LIMBS) : vlen;
    end

    // Decode strobes from the current state.
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        step_en    = (state == ST_RUN);
        load_carry = (state == ST_IDLE) && start;
    end

    // State, limb index and last-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx      <= '0;
                    last_idx <= IDX_W'(eff_len - LEN_W'(1));
                    state    <= (eff_len == '0) ? ST_DONE : ST_RUN;
                end
                ST_RUN: begin
                    if (idx == last_idx)
                        state <= ST_DONE;
                    else
                        idx <= idx + IDX_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bigint_scalar_mac.sv
// Top: multiplies a limb vector (unsigned, LS limb first) by a signed
// scalar plus signed carry, one limb per cycle, results written in place.
// Assumes: host accesses the limb buffer only while busy is low.
module bigint_scalar_mac #(
    parameter int LIMB_W    = 64,
    parameter int MAX_LIMBS = 8,
    localparam int LEN_W    = $clog2(MAX_LIMBS + 1),
    localparam int IDX_W    = $clog2(MAX_LIMBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  vlen,
    input  logic [LIMB_W-1:0] scalar,
    input  logic [LIMB_W-1:0] carry_in,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_addr,
    input  logic [LIMB_W-1:0] buf_wdata,
    output logic [LIMB_W-1:0] buf_rdata,
    output logic              busy,
    output logic              done,
    output logic [LIMB_W-1:0] carry_out
);
    logic              step_en;
    logic              load_carry;
    logic [IDX_W-1:0]  idx;
    logic [LIMB_W-1:0] scalar_r;
    logic [LIMB_W-1:0] carry_r;
    logic [LIMB_W-1:0] cur_limb;
    logic [LIMB_W-1:0] step_lo;
    logic [LIMB_W-1:0] step_hi;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_waddr;
    logic [LIMB_W-1:0] mem_wdata;

    bsm_ctrl #(.MAX_LIMBS(MAX_LIMBS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
        .busy(busy), .done(done), .step_en(step_en),
        .load_carry(load_carry), .idx(idx)
    );

    // Engine owns the write port while stepping; host writes only when idle.
    always_comb begin
        mem_we    = step_en || (buf_we && !busy);
        mem_waddr = step_en ? idx     : buf_addr;
        mem_wdata = step_en ? step_lo : buf_wdata;
    end

    bsm_limb_buf #(.W(LIMB_W), .DEPTH(MAX_LIMBS), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr_a(idx), .rdata_a(cur_limb),
        .raddr_b(buf_addr), .rdata_b(buf_rdata)
    );

    bsm_step #(.W(LIMB_W)) u_step (
        .limb(cur_limb), .scalar(scalar_r), .addend(carry_r),
        .lo(step_lo), .hi(step_hi)
    );

    // Scalar latch and chained carry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scalar_r <= '0;
            carry_r  <= '0;
        end else if (load_carry) begin
            scalar_r <= scalar;
            carry_r  <= carry_in;
        end else if (step_en) begin
            carry_r  <= step_hi;
        end
    end

    assign carry_out = carry_r;
endmodule

// File: rtl/bsm_chk.sv
// Protocol checker for bigint_scalar_mac, attached with bind.
// Assumes: observes top-level ports only.
module bsm_chk #(
    parameter int LIMB_W = 64,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  vlen,
    input logic              busy,
    input logic              done,
    input logic [LIMB_W-1:0] carry_out
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen == '0) |=> done);
    // R8
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen != '0) |=> (busy && !done));
    // R11
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(carry_out));
endmodule

bind bigint_scalar_mac bsm_chk #(.LIMB_W(LIMB_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .busy(busy), .done(done), .carry_out(carry_out)
);

// File: tb/sim_bigint_scalar_mac.sv
`timescale 1ns/1ps
module sim_bigint_scalar_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  vlen = '0;
    logic [63:0] scalar = '0;
    logic [63:0] carry_in = '0;
    logic        buf_we = 1'b0;
    logic [2:0]  buf_addr = '0;
    logic [63:0] buf_wdata = '0;
    logic [63:0] buf_rdata;
    logic        busy;
    logic        done;
    logic [63:0] carry_out;

    int checks = 0;
    int fails  = 0;
    logic [63:0] mirror [8];

    always #10 clk = ~clk;

    bigint_scalar_mac u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
        .scalar(scalar), .carry_in(carry_in), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .carry_out(carry_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
        summary();
    end

    // Reference step: unsigned limb times signed scalar plus signed carry.
    function automatic logic [127:0] ref_step(input logic [63:0] l,
            input logic [63:0] s, input logic [63:0] c);
        logic signed [129:0] v;
        v = $signed({66'd0, l}) * $signed({{66{s[63]}}, s})
            + $signed({{66{c[63]}}, c});
        return v[127:0];
    endfunction

    task automatic write_limb(input int i, input logic [63:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 3'(i); buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
        mirror[i] = v;
    endtask

    task automatic read_limb(input int i, output logic [63:0] v);
        buf_addr = 3'(i);
        #1;
        v = buf_rdata;
    endtask

    // Run one operation and check latency, pulse, limbs and carry.
    task automatic run_op(input int vl, input logic [63:0] s,
                          input logic [63:0] c, input bit interfere);
        int eff;
        int n;
        logic [63:0] carry_m;
        logic [127:0] r;
        logic [63:0] got;
        eff = (vl > 8) ? 8 : vl;
        carry_m = c;
        for (int i = 0; i < eff; i++) begin
            r = ref_step(mirror[i], s, carry_m);
            mirror[i] = r[63:0];
            carry_m = r[127:64];
        end
        @(negedge clk);
        start = 1'b1; vlen = 4'(vl); scalar = s; carry_in = c;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            if (interfere) begin
                // R8 R9: mid-run start and host write must be ignored
                start = 1'b1; vlen = 4'd1; scalar = 64'd3; carry_in = 64'd5;
                buf_we = 1'b1; buf_addr = 3'd7; buf_wdata = 64'hDEAD_BEEF;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0; buf_we = 1'b0;
        // R7: latency VL+1 edges
        check(n == eff + 1, "R7 latency", 64'(n), 64'(eff + 1));
        @(negedge clk);
        // R7: single-cycle pulse, then idle
        check(!done && !busy, "R7 pulse", {62'd0, done, busy}, 64'd0);
        // R1 R3 R6: carry-out
        check(carry_out == carry_m, "R3 carry_out", carry_out, carry_m);
        // R1 R4 R9: every limb, including untouched upper ones
        for (int i = 0; i < 8; i++) begin
            read_limb(i, got);
            check(got == mirror[i], (i < eff) ? "R1 limb" : "R4 upper limb",
                  got, mirror[i]);
        end
    endtask

    initial begin
        logic [63:0] got;
        logic [63:0] hold;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(!busy && !done, "R10 flags", {62'd0, busy, done}, 64'd0);
        check(carry_out == 64'd0, "R10 carry", carry_out, 64'd0);
        for (int i = 0; i < 8; i++) begin
            read_limb(i, got);
            check(got == 64'd0, "R10 limb", got, 64'd0);
        end

        // R2 R3: worked three-limb example
        write_limb(0, 64'h1357_0000_9BDF_0000);
        write_limb(1, 64'h9ABC_0000_DEF0_0000);
        write_limb(2, 64'h1234_0000_5678_0000);
        write_limb(3, 64'h0123_4567_89AB_CDEF);
        run_op(3, -64'sh1_0001, -64'shFEDC, 1'b0);
        read_limb(0, got);
        check(got == 64'hECA8_6420_6420_0124, "R2 limb0", got, 64'hECA8_6420_6420_0124);
        read_limb(1, got);
        check(got == 64'h6543_210F_210F_ECA8, "R2 limb1", got, 64'h6543_210F_210F_ECA8);
        read_limb(2, got);
        check(got == 64'hEDCB_A987_A987_6543, "R2 limb2", got, 64'hEDCB_A987_A987_6543);
        check(carry_out == 64'hFFFF_FFFF_FFFF_EDCB, "R3 example carry",
              carry_out, 64'hFFFF_FFFF_FFFF_EDCB);

        // R11: carry holds while idle with inputs moving
        hold = carry_out;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            carry_in = {$urandom, $urandom}; scalar = {$urandom, $urandom};
        end
        check(carry_out == hold, "R11 hold", carry_out, hold);

        // R6: zero length passes carry through
        run_op(0, 64'h7, 64'h8000_0000_0000_0001, 1'b0);
        check(carry_out == 64'h8000_0000_0000_0001, "R6 passthrough",
              carry_out, 64'h8000_0000_0000_0001);

        // R1: signed corners, all-ones limbs, most-negative scalar
        for (int i = 0; i < 8; i++) write_limb(i, '1);
        run_op(8, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        for (int i = 0; i < 8; i++) write_limb(i, '1);
        run_op(8, '1, '1, 1'b0);

        // R5: oversize length clamps to 8
        for (int i = 0; i < 8; i++) write_limb(i, {$urandom, $urandom});
        run_op(13, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);

        // R8 R9: interference during a short run leaves limb 7 alone
        for (int i = 0; i < 8; i++) write_limb(i, {$urandom, $urandom});
        run_op(4, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1);
        run_op(1, 64'hFFFF_FFFF_0000_0001, 64'd0, 1'b1);

        // R1 R4: random operations
        for (int t = 0; t < 30; t++) begin
            int vl;
            vl = 1 + int'($urandom % 8);
            for (int i = 0; i < 8; i++)
                if ($urandom % 2 == 0) write_limb(i, {$urandom, $urandom});
            run_op(vl, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
        end
        summary();
    end
endmodule